// File: doc/BRIEF.md
# Buffered Serial Word Receiver

The block turns a bit stream on an external serial data pin into 16-bit words. Timing comes entirely from the pins: an external bit clock and an external frame sync. The bit clock is treated as a level already synchronous to the core clock. The core clock samples it, and one of its two transitions is chosen as the active edge. A frame sync seen on an active edge starts a word. The next 16 active edges each shift one data bit into a shift register, either most-significant bit first or least-significant bit first.

Each completed word goes into a 32-entry buffer of 16-bit words. Software drains the buffer through a 32-bit read port that packs two words and removes both in one read. The block also reports how many words the buffer holds, whether a pair is ready, and a sticky overrun flag that marks any word lost because the buffer was full.

Top module: `serial_word_rx`

## Requirements
- R1: After reset, level_o is 0, pair_avail_o is 0 and overrun_o is 0. Only reset clears overrun_o.
- R2: With fall_edge_i=0 the active edge is a 0-to-1 change of sclk_i. With fall_edge_i=1 it is a 1-to-0 change. fsync_i and sdata_i are sampled only on active edges, so their values at the other transition have no effect.
- R3: level_o equals the number of buffered words and never exceeds 32.
- R4: fsync_i=1 on an active edge arms a new word, and the data bit on that edge is discarded. The next 16 active edges with fsync_i=0 supply the word's bits. The finished word is pushed into the buffer. fsync_i=1 in the middle of a word restarts the word. Bits that arrive while no word is armed are ignored.
- R5: With lsb_first_i=0 the first data bit lands in bit 15 of the word. With lsb_first_i=1 it lands in bit 0.
- R6: While level_o>=2, rd_data_o[15:0] holds the oldest buffered word and rd_data_o[31:16] holds the next oldest. Asserting rd_i for one cycle removes both words.
- R7: rd_i while level_o<2 is ignored: the level and the buffered words are unchanged.
- R8: A word completed while level_o is 32 is discarded and sets overrun_o.
- R9: pair_avail_o is 1 exactly when level_o>=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial bit clock, sampled level |
| fsync_i | input | 1 | Frame sync |
| sdata_i | input | 1 | Serial data |
| lsb_first_i | input | 1 | 1: least-significant bit first |
| fall_edge_i | input | 1 | 1: sample on the falling edge of sclk_i |
| rd_i | input | 1 | Read strobe: removes two words |
| rd_data_o | output | 32 | Oldest word in the low half, next oldest in the high half |
| level_o | output | 6 | Buffer occupancy in words |
| pair_avail_o | output | 1 | At least two words buffered |
| overrun_o | output | 1 | Sticky: a word was lost to a full buffer |

## Verification
The assertions take for granted that sclk_i holds each level for at least one core clock cycle, so two active edges are never in adjacent cycles. They also take for granted that fsync_i and sdata_i are valid in the cycle of the active edge. The bench holds every sclk_i phase for two cycles. It changes data at the active transition and drives the inverted data and a raised frame sync at the inactive transition, so sampling on the wrong edge corrupts the received words. All four combinations of bit order and edge are swept with arithmetically generated words.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_sel_e;
  typedef enum logic {ORDER_MSB = 1'b0, ORDER_LSB = 1'b1} bit_order_e;
endpackage

// File: rtl/srx_edge_det.sv
module srx_edge_det
  import serial_rx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sclk_i,
  input  edge_sel_e sel_i,
  output logic      strobe_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  always_comb begin
    if (sel_i == EDGE_RISE) strobe_o = sclk_i & ~sclk_q;
    else                    strobe_o = ~sclk_i & sclk_q;
  end
endmodule

// File: rtl/srx_deser.sv
module srx_deser
  import serial_rx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              fsync_i,
  input  logic              sdata_i,
  input  bit_order_e        order_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              armed_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sr_q, sr_nxt;

  always_comb begin
    if (order_i == ORDER_LSB) sr_nxt = {sdata_i, sr_q[WORD_W-1:1]};
    else                      sr_nxt = {sr_q[WORD_W-2:0], sdata_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      cnt_q      <= '0;
      sr_q       <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      if (strobe_i) begin
        if (fsync_i) begin
          // frame mark: next edge carries the first bit
          armed_q <= 1'b1;
          cnt_q   <= '0;
        end else if (armed_q) begin
          sr_q <= sr_nxt;
          if (cnt_q == LAST) begin
            armed_q    <= 1'b0;
            word_o     <= sr_nxt;
            word_vld_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  // R4: a word completes only at the end of an armed frame
  p_frame_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> !armed_q);
  p_single_push_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);
endmodule

// File: rtl/srx_pair_fifo.sv
module srx_pair_fifo #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [WORD_W-1:0]          push_data_i,
  input  logic                       pop_i,
  output logic [2*WORD_W-1:0]        pair_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  output logic                       overrun_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH+1);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] TOP  = PTR_W'(DEPTH - 1);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q, rd_ptr_p1, rd_ptr_p2;
  logic [LVL_W-1:0]  lvl_q, lvl_nxt;
  logic              push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == TOP) ? '0 : p + 1'b1;
  endfunction

  assign push_ok   = push_i && (lvl_q != FULL);
  assign pop_ok    = pop_i && (lvl_q >= LVL_W'(2));
  assign rd_ptr_p1 = inc(rd_ptr_q);
  assign rd_ptr_p2 = inc(rd_ptr_p1);
  assign pair_o    = {mem_q[rd_ptr_p1], mem_q[rd_ptr_q]};
  assign level_o   = lvl_q;

  always_comb begin
    lvl_nxt = lvl_q;
    if (push_ok) lvl_nxt = lvl_nxt + LVL_W'(1);
    if (pop_ok)  lvl_nxt = lvl_nxt - LVL_W'(2);
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      lvl_q     <= '0;
      overrun_o <= 1'b0;
    end else begin
      lvl_q <= lvl_nxt;
      if (push_ok) wr_ptr_q <= inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= rd_ptr_p2;
      if (push_i && !push_ok) overrun_o <= 1'b1;
    end
  end

  p_level_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= FULL);
  p_pop_two_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && lvl_q >= LVL_W'(2) && !push_i) |=> lvl_q == $past(lvl_q) - LVL_W'(2));
  p_short_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && lvl_q < LVL_W'(2) && !push_i) |=> $stable(lvl_q));
  p_full_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && lvl_q == FULL && !pop_i) |=> (lvl_q == FULL && overrun_o));
  p_ovr_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx
  import serial_rx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 32,
  localparam int LVL_W = $clog2(DEPTH+1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                fsync_i,
  input  logic                sdata_i,
  input  logic                lsb_first_i,
  input  logic                fall_edge_i,
  input  logic                rd_i,
  output logic [2*WORD_W-1:0] rd_data_o,
  output logic [LVL_W-1:0]    level_o,
  output logic                pair_avail_o,
  output logic                overrun_o
);
  logic              strobe;
  logic [WORD_W-1:0] word;
  logic              word_vld;
  edge_sel_e         edge_sel;
  bit_order_e        order;

  assign edge_sel = fall_edge_i ? EDGE_FALL : EDGE_RISE;
  assign order    = lsb_first_i ? ORDER_LSB : ORDER_MSB;

  srx_edge_det u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (sclk_i),
    .sel_i    (edge_sel),
    .strobe_o (strobe)
  );

  srx_deser #(.WORD_W(WORD_W)) u_deser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (strobe),
    .fsync_i    (fsync_i),
    .sdata_i    (sdata_i),
    .order_i    (order),
    .word_o     (word),
    .word_vld_o (word_vld)
  );

  srx_pair_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (word_vld),
    .push_data_i (word),
    .pop_i       (rd_i),
    .pair_o      (rd_data_o),
    .level_o     (level_o),
    .overrun_o   (overrun_o)
  );

  assign pair_avail_o = (level_o >= LVL_W'(2));

  // R9: a pair flag implies the read port can pop
  p_pair_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_avail_o && rd_i && !word_vld) |=> level_o == $past(level_o) - LVL_W'(2));
endmodule

// File: tb/serial_word_rx_test.sv
module serial_word_rx_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk_i = 1'b0, fsync_i = 1'b0, sdata_i = 1'b0;
  logic        lsb_first_i = 1'b0, fall_edge_i = 1'b0, rd_i = 1'b0;
  logic [31:0] rd_data_o;
  logic [5:0]  level_o;
  logic        pair_avail_o, overrun_o;

  int checks = 0, fails = 0;
  logic [15:0] model[$];

  always #(CLK_P/2) clk = ~clk;

  serial_word_rx uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk_i), .fsync_i(fsync_i),
    .sdata_i(sdata_i), .lsb_first_i(lsb_first_i), .fall_edge_i(fall_edge_i),
    .rd_i(rd_i), .rd_data_o(rd_data_o), .level_o(level_o),
    .pair_avail_o(pair_avail_o), .overrun_o(overrun_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    sclk_i = fall_edge_i;
    fsync_i = 1'b0; sdata_i = 1'b0; rd_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    model.delete();
    repeat (2) @(negedge clk);
  endtask

  // active transition carries fs/d; inactive transition carries inverted junk
  task automatic send_bit(input logic fs, input logic d);
    @(negedge clk);
    fsync_i = fs; sdata_i = d; sclk_i = ~fall_edge_i;
    repeat (2) @(negedge clk);
    fsync_i = ~fs; sdata_i = ~d; sclk_i = fall_edge_i;
    @(negedge clk);
    fsync_i = 1'b0; sdata_i = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w);
    send_bit(1'b1, 1'b0);
    for (int k = 0; k < 16; k++)
      send_bit(1'b0, lsb_first_i ? w[k] : w[15-k]);
    if (model.size() < 32) model.push_back(w);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic read_pair(input string req);
    logic [31:0] e;
    @(negedge clk);
    e = {model[1], model[0]};
    chk(req, rd_data_o, e);
    void'(model.pop_front());
    void'(model.pop_front());
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  function automatic logic [15:0] gen(input int i, input int k);
    return 16'h1F2D ^ 16'(i * 16'h3A71 + k * 16'h0515);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 level", 32'(level_o), 32'd0);
    chk("R1 pair", 32'(pair_avail_o), 32'd0);
    chk("R1 overrun", 32'(overrun_o), 32'd0);

    // sweep bit order and sampling edge
    for (int cfg = 0; cfg < 4; cfg++) begin
      lsb_first_i = cfg[0];
      fall_edge_i = cfg[1];
      do_reset();
      for (int i = 0; i < 6; i++) send_word(gen(i, cfg));
      settle();
      chk("R3 level after 6", 32'(level_o), 32'd6);
      chk("R9 pair flag", 32'(pair_avail_o), 32'd1);
      for (int p = 0; p < 3; p++) read_pair("R2 R5 R6 pair data");
      settle();
      chk("R6 drained", 32'(level_o), 32'd0);
      chk("R9 pair flag low", 32'(pair_avail_o), 32'd0);
    end

    // short read ignored
    lsb_first_i = 1'b0; fall_edge_i = 1'b0;
    do_reset();
    for (int i = 0; i < 3; i++) send_word(gen(i, 7));
    settle();
    read_pair("R6 odd batch");
    settle();
    chk("R9 single word", 32'(pair_avail_o), 32'd0);
    @(negedge clk); rd_i = 1'b1; @(negedge clk); rd_i = 1'b0;
    settle();
    chk("R7 level kept", 32'(level_o), 32'd1);
    send_word(gen(9, 7));
    settle();
    read_pair("R7 word kept");

    // framing: unframed bits ignored, fsync mid-word restarts
    for (int k = 0; k < 16; k++) send_bit(1'b0, k[0]);
    settle();
    chk("R4 unframed ignored", 32'(level_o), 32'd0);
    send_bit(1'b1, 1'b0);
    for (int k = 0; k < 5; k++) send_bit(1'b0, 1'b1);
    send_word(16'h8421);
    send_word(16'h0FF0);
    settle();
    chk("R4 restart level", 32'(level_o), 32'd2);
    read_pair("R4 restart data");

    // overrun
    lsb_first_i = 1'b1; fall_edge_i = 1'b1;
    do_reset();
    for (int i = 0; i < 34; i++) send_word(gen(i, 11));
    settle();
    chk("R3 full level", 32'(level_o), 32'd32);
    chk("R8 overrun set", 32'(overrun_o), 32'd1);
    for (int p = 0; p < 16; p++) read_pair("R8 kept words");
    settle();
    chk("R3 empty", 32'(level_o), 32'd0);
    chk("R8 sticky", 32'(overrun_o), 32'd1);
    do_reset();
    chk("R1 overrun cleared", 32'(overrun_o), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule